// File: doc/BRIEF.md
# Clock-Enable Configuration Serial Slave

This block is a two-wire serial slave that holds a small bank of clock-control registers and drives them as parallel outputs to the clock-enable logic beside it. The bus lines are sampled in the system clock domain through short synchronizer chains. Start and stop conditions, the address match, the acknowledge slot and the bit shifting are all recovered from those sampled lines. The slave only pulls the data line low through an open-drain enable and never drives the clock line.

A write frame always uses the same fixed layout. The address byte comes first. Two framing bytes follow: a command code and a byte count. Both are acknowledged and thrown away. Every byte after them is stored in the next register, starting at register 0, and loading goes on until a stop. A read frame starts returning register contents at once, from register 0 upwards, with no count byte in front of them. While the power-down input is high the block ignores the bus, keeps its data line released and holds all register values.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The slave pulls SDA low in the ninth clock of every byte it accepts: the matching address byte, both framing bytes and every data byte.
- R2: An address byte whose upper seven bits differ from the slave address (default 7'h69) is not acknowledged. The rest of that frame changes no register and gets no acknowledge.
- R3: The two bytes after a write address are acknowledged but change no register.
- R4: The third and later bytes of a write frame go to registers 0, 1, 2 and so on, one register per completed byte. Register i appears on `regs_out[8*i+7:8*i]`.
- R5: A stop after any complete byte ends the frame, and every register already written keeps its new value. A byte cut short by a stop writes nothing.
- R6: Data bytes beyond register 6 are acknowledged and dropped.
- R7: When the address byte has bit 0 set, the slave sends register 0, then 1, and so on, MSB first, with no count byte. It sends 8'hFF for any index past register 6 and stops sending after the master NACKs.
- R8: After reset, register 0 holds 8'h00 and registers 1 to 6 hold 8'hFF, and SDA is released.
- R9: While `pwr_down` is high, SDA is released, bus activity is ignored and every register keeps its value.
- R10: A start condition is an SDA fall while SCL is high and a stop condition is an SDA rise while SCL is high. A repeated start restarts the framing, so the address byte is expected next and the register index returns to 0.
- R11: The SDA output enable changes only while SCL is low, except when it is released by a start, a stop or power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | High: release the bus and ignore it, keeping the registers |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High: pull SDA low |
| regs_out | output | 56 | Register bank, register i at bits 8*i+7:8*i |

## Verification
Some rules are checked by the assertions on every cycle:
- the SDA enable changes only after an SCL fall or a release event;
- power-down and stop release the line;
- a power-down cycle leaves the register outputs untouched;
- each write strobe puts its byte into the register it names.

Other behaviour only shows up when the bench's bus frames are played back:
- the frame-level rules: the discarded framing bytes, the ascending register order, stopping after each possible byte count, dropping overflow writes;
- read-back order with its 8'hFF tail;
- the restart of framing on a repeated start;
- refusing a foreign address.

// File: rtl/clkcfg_pkg.sv
// Package: shared types and constants for the clock-enable configuration slave.
// Assumes one byte per register and a fixed two-byte preamble on write frames.
package clkcfg_pkg;

    // Transfer engine states.
    typedef enum logic [2:0] {
        ST_IDLE,   // no frame in progress
        ST_RX,     // shifting in address or write byte
        ST_ACK,    // slave holding SDA low for the acknowledge slot
        ST_TX,     // slave shifting out a read byte
        ST_MACK,   // master acknowledge slot after a read byte
        ST_WAIT    // frame ignored until next start or stop
    } cfg_state_e;

    // Bytes after the write address that are acknowledged and thrown away.
    localparam int unsigned PREAMBLE_BYTES = 2;

    // Value returned for reads past the implemented registers.
    localparam logic [7:0] EMPTY_READ = 8'hFF;

    // Power-on value of register idx: register 0 clear, the rest all enabled.
    function automatic logic [7:0] reg_default(input int unsigned idx);
        return (idx == 0) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
// Module: brings the SCL/SDA pad levels into the clk domain and flags edges.
// Assumes the bus is much slower than clk, so every level lasts several clocks.
// Outputs are registered levels plus single-cycle event strobes.
module clkcfg_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture flop of each line, idle-high after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else begin
                    scl_chain[g] <= scl_in;
                    sda_chain[g] <= sda_in;
                end
            end
        end else begin : g_next
            // Purpose: further synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else begin
                    scl_chain[g] <= scl_chain[g-1];
                    sda_chain[g] <= sda_chain[g-1];
                end
            end
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // Purpose: one-cycle history of the synchronized lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Purpose: derive clock edges and start/stop from SDA moving under a high SCL.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/clkcfg_reg_bank.sv
// Module: register bank with per-register power-on defaults and one write port.
// Assumes the write strobe is a single cycle; out-of-range reads give EMPTY_READ.
module clkcfg_reg_bank
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 7,
    parameter int unsigned IDX_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [7:0] bank_q [NUM_REGS];

    // Purpose: load defaults on reset, else store the strobed byte at its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q[i] <= reg_default(i);
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    bank_q[i] <= wr_data;
                end
            end
        end
    end

    // Purpose: read mux with a fixed fill value past the last register.
    always_comb begin
        rd_data = EMPTY_READ;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = bank_q[i];
            end
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
        assign regs_flat[8*i +: 8] = bank_q[i];

        // A strobed write lands in exactly the addressed register (R4).
        p_write_lands_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i)) |=> (regs_flat[8*i +: 8] == $past(wr_data)));
    end

endmodule

// File: rtl/clkcfg_xfer_fsm.sv
// Module: frame engine for the configuration slave. Recognizes the address,
// drives acknowledges, drops the two preamble bytes, issues register writes
// and shifts read data out MSB first.
// Assumes synchronized inputs and event strobes from clkcfg_line_sync; only
// changes SDA after an SCL fall so the line is stable while SCL is high.
module clkcfg_xfer_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]  SLV_ADDR = 7'h69,
    parameter int unsigned NUM_REGS = 7,
    parameter int unsigned IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_oe
);

    localparam logic [3:0]       BITS_PER_BYTE = 4'd8;
    localparam logic [IDX_W-1:0] SKIP_CNT      = IDX_W'(PREAMBLE_BYTES);
    localparam logic [IDX_W-1:0] REG_CNT       = IDX_W'(NUM_REGS);

    cfg_state_e       state_q;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       rx_sh_q;
    logic [7:0]       tx_sh_q;
    logic [IDX_W-1:0] byte_cnt_q;
    logic             first_q;
    logic             rw_q;
    logic             mack_q;
    logic             bus_ok;
    logic             rx_done;

    // Purpose: qualify bus events and decode the write strobe for the bank.
    always_comb begin
        bus_ok  = ~pwr_down & ~start_det & ~stop_det;
        rx_done = bus_ok && (state_q == ST_RX) && scl_fall && (bit_cnt_q == BITS_PER_BYTE);
        wr_idx  = byte_cnt_q - SKIP_CNT;
        wr_data = rx_sh_q;
        wr_en   = rx_done && !first_q && (byte_cnt_q >= SKIP_CNT) && (wr_idx < REG_CNT);
        rd_idx  = byte_cnt_q;
    end

    // Purpose: frame sequencing, bit shifting and open-drain SDA control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            byte_cnt_q <= '0;
            first_q    <= 1'b0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (pwr_down) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            sda_oe    <= 1'b0;
        end else if (start_det) begin
            state_q    <= ST_RX;
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            first_q    <= 1'b1;
            rw_q       <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (scl_rise && bit_cnt_q < BITS_PER_BYTE) begin
                        rx_sh_q   <= {rx_sh_q[6:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end
                    if (rx_done) begin
                        bit_cnt_q <= '0;
                        if (first_q) begin
                            if (rx_sh_q[7:1] == SLV_ADDR) begin
                                rw_q    <= rx_sh_q[0];
                                state_q <= ST_ACK;
                                sda_oe  <= 1'b1;
                            end else begin
                                state_q <= ST_WAIT;
                            end
                        end else begin
                            state_q <= ST_ACK;
                            sda_oe  <= 1'b1;
                            if (byte_cnt_q != '1) begin
                                byte_cnt_q <= byte_cnt_q + 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        first_q <= 1'b0;
                        if (first_q && rw_q) begin
                            state_q   <= ST_TX;
                            tx_sh_q   <= rd_data;
                            sda_oe    <= ~rd_data[7];
                            bit_cnt_q <= '0;
                        end else begin
                            state_q <= ST_RX;
                            sda_oe  <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt_q == BITS_PER_BYTE - 4'd1) begin
                            sda_oe  <= 1'b0;
                            state_q <= ST_MACK;
                            if (byte_cnt_q != '1) begin
                                byte_cnt_q <= byte_cnt_q + 1'b1;
                            end
                        end else begin
                            tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
                            sda_oe    <= ~tx_sh_q[6];
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                    end
                    if (scl_fall) begin
                        if (mack_q) begin
                            state_q   <= ST_TX;
                            tx_sh_q   <= rd_data;
                            sda_oe    <= ~rd_data[7];
                            bit_cnt_q <= '0;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                default: begin
                    // ST_IDLE and ST_WAIT: hold until a start or stop.
                end
            endcase
        end
    end

    // SDA enable moves only after an SCL fall or a release event (R11).
    p_sda_on_fall_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det || pwr_down));

    // Power-down releases the data line on the next cycle (R9).
    p_pdn_release_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !sda_oe);

    // A stop condition releases the data line (R10).
    p_stop_release_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // The bit counter never runs past one byte plus its acknowledge (R1).
    p_bitcnt_bound_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= BITS_PER_BYTE);

endmodule

// File: rtl/clkcfg_serial_slave.sv
// Module: top of the clock-enable configuration slave. Joins the line
// synchronizer, the frame engine and the register bank, and exposes the bank
// as one flat vector for the clock-enable logic.
// Assumes SDA is wired-AND on the board: sda_oe high pulls the line low.
module clkcfg_serial_slave #(
    parameter logic [6:0]  SLV_ADDR    = 7'h69,
    parameter int unsigned NUM_REGS    = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_down,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_out
);

    import clkcfg_pkg::*;

    // Index wide enough for preamble plus all registers, with saturation room.
    localparam int unsigned IDX_W = $clog2(NUM_REGS + PREAMBLE_BYTES + 1) + 1;

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    clkcfg_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_xfer_fsm #(
        .SLV_ADDR (SLV_ADDR),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe)
    );

    clkcfg_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (regs_out)
    );

    // Register outputs hold still across a power-down cycle (R9).
    p_retain_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(regs_out));

    // scl_s is the settled line level; unused beyond the synchronizer here.
    logic unused_scl;
    assign unused_scl = scl_s;

endmodule

// File: tb/test_clkcfg_serial_slave.sv
// Bench: bit-banged bus master with a reference register model.
module test_clkcfg_serial_slave;

    localparam int NREG = 7;
    localparam logic [6:0] ADDR = 7'h69;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs_out;
    wire  sda_line = sda_oe ? 1'b0 : m_sda;

    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_q [NREG];
    logic [7:0] pay [16];

    always #10 clk = ~clk;

    clkcfg_serial_slave i_clkcfg_serial_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .regs_out (regs_out)
    );

    // R11 monitor: slave enable must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && m_scl && (sda_oe !== prev_oe)) oe_viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[8*i +: 8] = exp_q[i];
        return v;
    endfunction

    task automatic hp();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; hp();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0;
        end
        m_sda = 1'b1; hp(); m_scl = 1'b1;
        repeat (4) @(negedge clk);
        acked = !sda_line;
        repeat (4) @(negedge clk);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); m_scl = 1'b1;
            repeat (4) @(negedge clk);
            b[i] = sda_line;
            repeat (4) @(negedge clk);
            m_scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0; m_sda = 1'b1;
    endtask

    // Full write frame: address, two preamble bytes, n data bytes from pay, stop.
    task automatic write_frame(input logic [6:0] addr, input int n, output int acks);
        logic a;
        acks = 0;
        bus_start();
        send_byte({addr, 1'b0}, a); acks += int'(a);
        send_byte(8'hC3, a); acks += int'(a);
        send_byte(8'h05, a); acks += int'(a);
        for (int k = 0; k < n; k++) begin
            send_byte(pay[k], a); acks += int'(a);
        end
        bus_stop();
        if (addr == ADDR && !pwr_down)
            for (int k = 0; k < n && k < NREG; k++) exp_q[k] = pay[k];
    endtask

    initial begin
        logic a;
        logic [7:0] rb;
        int acks;
        for (int i = 0; i < NREG; i++) exp_q[i] = (i == 0) ? 8'h00 : 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: power-on contents and released line.
        check(regs_out == exp_flat(), "R8 defaults", 64'(regs_out), 64'(exp_flat()));
        check(sda_oe == 1'b0, "R8 sda released", 64'(sda_oe), 64'd0);

        // R5: stop after each possible number of data bytes.
        for (int n = 1; n <= NREG; n++) begin
            for (int k = 0; k < n; k++) pay[k] = 8'((n << 4) | k);
            write_frame(ADDR, n, acks);
            check(acks == n + 3, "R1 acks per byte", 64'(acks), 64'(n + 3));
            check(regs_out == exp_flat(), "R5 stop after byte", 64'(regs_out), 64'(exp_flat()));
        end

        // R3/R4/R6: nine data bytes, preamble dropped, ascending order, overflow dropped.
        for (int k = 0; k < 9; k++) pay[k] = 8'(8'h31 * (k + 1));
        write_frame(ADDR, 9, acks);
        check(acks == 12, "R6 overflow acked", 64'(acks), 64'd12);
        check(regs_out == exp_flat(), "R4 ascending load", 64'(regs_out), 64'(exp_flat()));
        check(regs_out[7:0] == 8'h31, "R3 preamble not stored", 64'(regs_out[7:0]), 64'h31);

        // R2: foreign address refused, nothing written.
        for (int k = 0; k < 3; k++) pay[k] = 8'h00;
        write_frame(7'h2A, 3, acks);
        check(acks == 0, "R2 no ack", 64'(acks), 64'd0);
        check(regs_out == exp_flat(), "R2 regs kept", 64'(regs_out), 64'(exp_flat()));

        // R5: stop inside a byte writes nothing for that byte.
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 3; i++) begin
            m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0;
        end
        bus_stop();
        check(regs_out == exp_flat(), "R5 partial byte", 64'(regs_out), 64'(exp_flat()));

        // R7: read back every register plus one past the end.
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        check(a == 1'b1, "R1 read address ack", 64'(a), 64'd1);
        for (int k = 0; k <= NREG; k++) begin
            recv_byte(k != NREG, rb);
            check(rb == ((k < NREG) ? exp_q[k] : 8'hFF), "R7 read data", 64'(rb),
                  64'((k < NREG) ? exp_q[k] : 8'hFF));
        end
        bus_stop();

        // R7: after a NACK the slave leaves the line alone.
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(1'b0, rb);
        check(rb == exp_q[0], "R7 short read", 64'(rb), 64'(exp_q[0]));
        hp();
        check(sda_oe == 1'b0, "R7 silent after nack", 64'(sda_oe), 64'd0);
        bus_stop();

        // R10: repeated start restarts framing in a write.
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h11, a);
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h22, a);
        bus_stop();
        exp_q[0] = 8'h22;
        check(regs_out == exp_flat(), "R10 restart write", 64'(regs_out), 64'(exp_flat()));

        // R10: repeated start turns a write into a read from register 0.
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(1'b0, rb);
        bus_stop();
        check(rb == exp_q[0], "R10 restart read", 64'(rb), 64'(exp_q[0]));

        // R9: power-down ignores a full frame and keeps registers.
        pwr_down = 1'b1;
        hp();
        for (int k = 0; k < 4; k++) pay[k] = 8'h5A;
        write_frame(ADDR, 4, acks);
        check(acks == 0, "R9 no ack in power-down", 64'(acks), 64'd0);
        check(regs_out == exp_flat(), "R9 regs retained", 64'(regs_out), 64'(exp_flat()));
        pwr_down = 1'b0;
        hp();
        pay[0] = 8'h77;
        write_frame(ADDR, 1, acks);
        check(regs_out == exp_flat(), "R9 resume after power-down", 64'(regs_out), 64'(exp_flat()));

        // R11: enable never moved while SCL was high.
        check(oe_viol == 0, "R11 sda stable under high scl", 64'(oe_viol), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule